// File: doc/BRIEF.md
# Checked Signed Arithmetic Unit

This block is a signed two's-complement arithmetic unit for a small datapath. It adds, subtracts or multiplies two operands of a configurable width (16 bits by default) and registers a result truncated to the operand width. Each operation is evaluated at full precision before truncation. Addition and subtraction use operands widened by one sign bit. Multiplication uses a product twice the operand width. The full-precision value is then compared against the representable range, which yields two flags: one for a result above the largest positive value (overflow) and one for a result below the most negative value (underflow).

An operation is presented with a one-cycle valid strobe. The result and both flags update on the clock edge that samples the strobe. Either flag also sets a sticky halt output in that same edge. Halt stays asserted until reset and freezes the result and flags, so a controller can stop and inspect the faulting value.

Top module: `chk_alu`

## Requirements
- R1: After reset the result, the overflow flag, the underflow flag and halt are all zero.
- R2: Opcode 2'b00 adds. The result is the low W bits of a+b. Overflow is set when the exact sum exceeds 2^(W-1)-1, and underflow when it is below -2^(W-1).
- R3: Opcode 2'b01 subtracts b from a. The result is the low W bits of a-b, and the flags follow the same range rule as R2.
- R4: Opcode 2'b10 multiplies. The result is the low W bits of the 2W-bit product, and the flags follow the same range rule applied to the full product.
- R5: Opcode 2'b11 is reserved. It gives a zero result with both flags cleared.
- R6: Result and flags update on the clock edge that samples in_valid high. With in_valid low they hold their values.
- R7: Halt rises in the same edge as an overflow or underflow flag. Once set it stays high until reset.
- R8: While halt is high, valid strobes change neither the result nor the flags.
- R9: Boundary cases: min*(-1) sets overflow, min*1 sets no flag, max+1 sets overflow, and min-1 sets underflow.
- R10: Overflow and underflow are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | Opcode: 00 add, 01 sub, 10 mul, 11 reserved |
| opa | input | W | Signed operand a |
| opb | input | W | Signed operand b |
| res | output | W | Registered truncated signed result |
| ovf | output | 1 | Registered overflow flag (result too large) |
| unf | output | 1 | Registered underflow flag (result too negative) |
| halt | output | 1 | Sticky fault, set by either flag |

## Verification
The bench builds the unit twice. One instance uses the default W=16, and directed scenarios run on it: the reset state, ordinary sums, differences and products, the reserved opcode, holding with the strobe low, the halt freeze and the extreme-value corners. A second instance uses W=4, which keeps the operand space small enough to sweep every operand pair for all three operations. That sweep reaches each sign-combination overflow and underflow path, and every truncation, against a reference computed from exact integer arithmetic.

// File: rtl/chk_alu_pkg.sv
package chk_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_RSV = 2'b11
  } alu_op_e;
endpackage

// File: rtl/chk_addsub.sv
module chk_addsub #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         pos_ovf,
  output logic         neg_ovf
);
  localparam int XW = W + 1;

  logic [XW-1:0] ax, bx_raw, bx, wide;

  always_comb begin
    ax     = {a[W-1], a};
    bx_raw = {b[W-1], b};
    bx     = sub ? (~bx_raw + XW'(1)) : bx_raw;
    wide   = ax + bx;
  end

  assign sum     = wide[W-1:0];
  assign pos_ovf = (wide[XW-1:W-1] == 2'b01);
  assign neg_ovf = (wide[XW-1:W-1] == 2'b10);

  // R2
  add_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub && pos_ovf) |-> (!a[W-1] && !b[W-1] && sum[W-1]));
  // R3
  sub_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub && neg_ovf) |-> (a[W-1] && !b[W-1] && !sum[W-1]));
endmodule

// File: rtl/chk_mul.sv
module chk_mul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod,
  output logic         pos_ovf,
  output logic         neg_ovf
);
  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] MAXV = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [W-1:0]  as, bs;
  logic signed [PW-1:0] full;

  assign as      = a;
  assign bs      = b;
  assign full    = as * bs;
  assign prod    = full[W-1:0];
  assign pos_ovf = (full > MAXV);
  assign neg_ovf = (full < MINV);

  // R4
  mul_pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_ovf |-> (a[W-1] == b[W-1]));
  // R4
  mul_neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    neg_ovf |-> (a[W-1] != b[W-1]));
endmodule

// File: rtl/chk_alu.sv
module chk_alu
  import chk_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res,
  output logic         ovf,
  output logic         unf,
  output logic         halt
);
  alu_op_e       op_e;
  logic [W-1:0]  as_sum, mul_lo;
  logic          as_pos, as_neg, mul_pos, mul_neg;
  logic [W-1:0]  sel_res;
  logic          sel_ovf, sel_unf;
  logic          upd_en;
  logic [W-1:0]  res_q, res_d;
  logic          ovf_q, ovf_d, unf_q, unf_d, halt_q, halt_d;

  assign op_e = alu_op_e'(op);

  chk_addsub #(.W(W)) u_addsub (
    .clk(clk), .rst_n(rst_n), .a(opa), .b(opb), .sub(op_e == OP_SUB),
    .sum(as_sum), .pos_ovf(as_pos), .neg_ovf(as_neg)
  );

  chk_mul #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .a(opa), .b(opb),
    .prod(mul_lo), .pos_ovf(mul_pos), .neg_ovf(mul_neg)
  );

  always_comb begin
    case (op_e)
      OP_ADD, OP_SUB: begin
        sel_res = as_sum;
        sel_ovf = as_pos;
        sel_unf = as_neg;
      end
      OP_MUL: begin
        sel_res = mul_lo;
        sel_ovf = mul_pos;
        sel_unf = mul_neg;
      end
      default: begin
        sel_res = '0;
        sel_ovf = 1'b0;
        sel_unf = 1'b0;
      end
    endcase
  end

  assign upd_en = in_valid && !halt_q;

  always_comb begin
    res_d  = res_q;
    ovf_d  = ovf_q;
    unf_d  = unf_q;
    halt_d = halt_q;
    if (upd_en) begin
      res_d  = sel_res;
      ovf_d  = sel_ovf;
      unf_d  = sel_unf;
      halt_d = sel_ovf || sel_unf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
      halt_q <= halt_d;
    end
  end

  assign res  = res_q;
  assign ovf  = ovf_q;
  assign unf  = unf_q;
  assign halt = halt_q;

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
  // R7
  flag_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf || unf) |-> halt);
  // R8
  frozen_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> ($stable(res) && $stable(ovf) && $stable(unf)));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res) && $stable(ovf) && $stable(unf)));
  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));
  // R5
  rsv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !halt && op == 2'b11) |=> (res == '0 && !ovf && !unf));
endmodule

// File: tb/chk_alu_bench.sv
module chk_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 16;
  localparam int NW = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic          rst_n, vld, ovf, unf, halt;
  logic [1:0]    op;
  logic [WW-1:0] a, b, res;

  logic          n_rst_n, n_vld, n_ovf, n_unf, n_halt;
  logic [1:0]    n_op;
  logic [NW-1:0] n_a, n_b, n_res;

  chk_alu #(.W(WW)) u_chk_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .op(op), .opa(a), .opb(b),
    .res(res), .ovf(ovf), .unf(unf), .halt(halt)
  );

  chk_alu #(.W(NW)) u_narrow (
    .clk(clk), .rst_n(n_rst_n), .in_valid(n_vld), .op(n_op), .opa(n_a), .opb(n_b),
    .res(n_res), .ovf(n_ovf), .unf(n_unf), .halt(n_halt)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint ref_full(input int o, input longint x, input longint y);
    case (o)
      0: return x + y;
      1: return x - y;
      2: return x * y;
      default: return 0;
    endcase
  endfunction

  task automatic wide_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic run_wide(input int o, input longint x, input longint y, input string tag);
    longint f;
    logic [WW-1:0] er;
    bit eo, eu;
    if (halt) wide_reset();
    @(negedge clk);
    vld = 1'b1; op = 2'(o); a = WW'(x); b = WW'(y);
    @(negedge clk);
    vld = 1'b0;
    f  = ref_full(o, x, y);
    er = WW'(f);
    eo = f > 32767;
    eu = f < -32768;
    chk(res == er, {tag, " result"}, longint'($signed(res)), longint'($signed(er)));
    chk(ovf == eo, {tag, " ovf"}, ovf, eo);
    chk(unf == eu, {tag, " unf"}, unf, eu);
    chk(halt == (eo | eu), {tag, " R7 halt"}, halt, eo | eu);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; vld = 1'b0; op = '0; a = '0; b = '0;
    repeat (2) @(negedge clk);
    chk(res == '0 && !ovf && !unf && !halt, "R1 reset state", res, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_add();
    run_wide(0, 100, 23, "R2 add small");
    run_wide(0, -500, 200, "R2 add mixed");
    run_wide(0, 30000, 10000, "R2 add overflow");
    run_wide(0, -30000, -10000, "R2 add underflow");
    run_wide(0, -1, -1, "R2 add negs");
  endtask

  task automatic t_sub();
    run_wide(1, 50, 80, "R3 sub");
    run_wide(1, 20000, -20000, "R3 sub overflow");
    run_wide(1, -20000, 20000, "R3 sub underflow");
    run_wide(1, -32768, -32768, "R3 sub min-min");
  endtask

  task automatic t_mul();
    run_wide(2, 123, -45, "R4 mul");
    run_wide(2, 181, 181, "R4 mul fits");
    run_wide(2, 300, 300, "R4 mul overflow");
    run_wide(2, -300, 300, "R4 mul underflow");
  endtask

  task automatic t_reserved();
    run_wide(0, 7, 8, "R5 prime");
    run_wide(3, 1234, 5678, "R5 reserved");
  endtask

  task automatic t_hold();
    logic [WW-1:0] keep;
    run_wide(0, 1000, 234, "R6 setup");
    keep = res;
    @(negedge clk); op = 2'b10; a = 16'h7fff; b = 16'h7fff;
    repeat (3) @(negedge clk);
    chk(res == keep && !ovf && !unf && !halt, "R6 hold without strobe", res, keep);
  endtask

  task automatic t_boundary();
    run_wide(2, -32768, -1, "R9 min*-1");
    run_wide(2, -32768, 1, "R9 min*1");
    run_wide(0, 32767, 1, "R9 max+1");
    run_wide(1, -32768, 1, "R9 min-1");
  endtask

  task automatic t_halt();
    logic [WW-1:0] keep;
    run_wide(0, 32767, 32767, "R7 trip");
    keep = res;
    @(negedge clk); vld = 1'b1; op = 2'b00; a = 16'd1; b = 16'd1;
    @(negedge clk); vld = 1'b0;
    chk(res == keep, "R8 frozen result", res, keep);
    chk(ovf && !unf && halt, "R8 frozen flags", {ovf, unf, halt}, 3'b101);
    repeat (2) @(negedge clk);
    chk(halt, "R7 sticky", halt, 1);
    wide_reset();
    chk(!halt && res == '0, "R1 R7 reset clears halt", halt, 0);
  endtask

  task automatic t_narrow_sweep();
    n_vld = 1'b0; n_op = '0; n_a = '0; n_b = '0;
    for (int o = 0; o < 3; o++) begin
      for (int x = -8; x < 8; x++) begin
        for (int y = -8; y < 8; y++) begin
          longint f;
          logic [NW-1:0] er;
          bit eo, eu;
          @(negedge clk); n_rst_n = 1'b0;
          @(negedge clk); n_rst_n = 1'b1;
          n_vld = 1'b1; n_op = 2'(o); n_a = NW'(x); n_b = NW'(y);
          @(negedge clk); n_vld = 1'b0;
          f  = ref_full(o, x, y);
          er = NW'(f);
          eo = f > 7;
          eu = f < -8;
          chk(n_res == er && n_ovf == eo && n_unf == eu && n_halt == (eo | eu),
              $sformatf("R2 R3 R4 R10 narrow op%0d %0d,%0d", o, x, y),
              {n_res, n_ovf, n_unf, n_halt}, {er, eo, eu, eo | eu});
        end
      end
    end
  endtask

  initial begin
    n_rst_n = 1'b0;
    t_reset();
    t_add();
    t_sub();
    t_mul();
    t_reserved();
    t_hold();
    t_boundary();
    t_halt();
    t_narrow_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule